// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames, one byte per beat on a valid/ready stream, and stores each one through a ring of 32-byte receive descriptors in system memory. When a frame begins, it reads three words of the descriptor at its current ring pointer: the control/status word, the buffer-size word and the buffer address. It then packs the frame bytes into 32-bit words and writes them to the buffer. When the frame ends it decides the outcome. It may drop the frame as too short, discard it because the descriptor is not owned by the hardware, or complete it. On completion it writes the length and status back into the descriptor and moves the pointer on.

Every outcome is reported to a status register elsewhere as single-cycle set pulses. Completed frames also update four free-running statistics counters: stored bytes (CRC included), frames, broadcast frames and multicast frames. Memory is reached through one word-wide port. A read returns data on `mem_rdata` two clock edges after the request is registered, as a registered block RAM would.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the counters read zero, no status pulse is active, `mem_en` is low and `s_ready` is low while no frame is pending.
- R2: A frame that begins while `rx_en` is low is consumed and has no other effect: no memory write, no status pulse, no counter change and no pointer movement. Its first byte is accepted on the second rising edge with `s_valid` high.
- R3: A frame shorter than 12 bytes pulses `st_ri` and `st_nis` (not `st_ru`/`st_ais`). It leaves the descriptor word, the counters and the pointer unchanged. This holds even when the descriptor is not owned.
- R4: A frame of 12 or more bytes whose descriptor word 0 has bit 31 clear pulses `st_ru` and `st_ais` (not `st_ri`). It writes nothing to memory and leaves the counters and the pointer unchanged.
- R5: For a stored frame, byte i goes to buffer address + 4*(i/4), in byte lane i%4 (bits 8*(i%4)+7 down to 8*(i%4)). The buffer address is word 2 of the descriptor and must be word-aligned. Lanes past the last byte are not written.
- R6: A stored frame's descriptor word 0 is rewritten as ((length + 4) << 16) | 0x300, which clears bit 31.
- R7: After a stored frame the pointer moves on by 32 bytes. If bit 15 of descriptor word 1 is set, it reloads from `ring_base` instead. A `ring_base_load` pulse also loads `ring_base`.
- R8: A stored frame adds length+4 to `cnt_bytes` and one to `cnt_frames`. If destination bytes 0..5 are all 0xFF it adds one to `cnt_bcast`. Otherwise, if bit 0 of byte 0 is set, it adds one to `cnt_mcast`. Otherwise (unicast) neither class counter changes. The counters wrap silently.
- R9: A stored frame pulses `st_ri` and `st_nis` for one cycle.
- R10: With `rx_en` high, `s_ready` stays low while the descriptor is fetched: the first byte is accepted on the seventh rising edge with `s_valid` high. No read is ever issued while `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable, sampled when a frame begins |
| ring_base | input | ADDR_W | Byte address of the first descriptor in the ring |
| ring_base_load | input | 1 | Pulse: load the ring pointer from `ring_base` |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_ready | output | 1 | Stream byte accepted when high with `s_valid` |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_be | output | 4 | Byte enables for writes |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid two edges after the request is registered |
| st_ri | output | 1 | Set pulse: receive interrupt |
| st_nis | output | 1 | Set pulse: normal summary |
| st_ru | output | 1 | Set pulse: receive buffer unavailable |
| st_ais | output | 1 | Set pulse: abnormal summary |
| cnt_bytes | output | CNT_W | Stored bytes including CRC |
| cnt_frames | output | CNT_W | Stored frames |
| cnt_bcast | output | CNT_W | Stored broadcast frames |
| cnt_mcast | output | CNT_W | Stored multicast frames |

## Verification
The final byte of a frame is accepted on some edge. One edge later the status pulses and counters update, and the descriptor write request is registered. Memory takes that write one edge after that. The bench therefore waits three edges after the last accepted byte and checks at the following falling edge. The status pulses last only one cycle, so a monitor counts them at every rising edge. The bench also counts the rising edges from presenting the first byte to its acceptance, which checks the fetch stall length for enabled and disabled frames.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DATA,
    ST_SKIP,
    ST_FIN
  } rxw_state_e;

  localparam int unsigned DESC_BYTES = 32;
  localparam int unsigned CRC_BYTES  = 4;
  localparam int unsigned MIN_FRAME  = 12;
  localparam int unsigned OWN_BIT    = 31;
  localparam int unsigned WRAP_BIT   = 15;
  localparam logic [31:0] WB_FLAGS   = 32'h0000_0300;
endpackage

// File: rtl/rxw_classify.sv
module rxw_classify #(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             beat,
  input  logic [LEN_W-1:0] idx,
  input  logic [7:0]       data,
  output logic             is_bcast,
  output logic             is_mcast
);
  localparam int DA_BYTES = 6;

  logic first_lsb;
  logic all_ones;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      first_lsb <= 1'b0;
      all_ones  <= 1'b1;
    end else if (beat) begin
      if (idx == '0) first_lsb <= data[0];
      if (idx < LEN_W'(DA_BYTES) && data != 8'hFF) all_ones <= 1'b0;
    end
  end

  assign is_bcast = all_ones;
  assign is_mcast = first_lsb && !all_ones;
endmodule

// File: rtl/rxw_stats.sv
module rxw_stats
  import rxw_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [LEN_W:0]   add_bytes,
  input  logic             bcast,
  input  logic             mcast,
  output logic [CNT_W-1:0] cnt_bytes,
  output logic [CNT_W-1:0] cnt_frames,
  output logic [CNT_W-1:0] cnt_bcast,
  output logic [CNT_W-1:0] cnt_mcast
);
  localparam int unsigned MIN_ADD = MIN_FRAME + CRC_BYTES;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_bytes  <= '0;
      cnt_frames <= '0;
      cnt_bcast  <= '0;
      cnt_mcast  <= '0;
    end else if (upd) begin
      cnt_bytes  <= cnt_bytes + CNT_W'(add_bytes);
      cnt_frames <= cnt_frames + 1'b1;
      if (bcast) cnt_bcast <= cnt_bcast + 1'b1;
      if (mcast) cnt_mcast <= cnt_mcast + 1'b1;
    end
  end

  // R8
  frames_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_frames != $past(cnt_frames)) |-> (cnt_frames == $past(cnt_frames) + 1'b1));

  // R8
  bytes_min_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_frames != $past(cnt_frames)) |-> ((cnt_bytes - $past(cnt_bytes)) >= CNT_W'(MIN_ADD)));

  // R8
  class_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_bcast != $past(cnt_bcast)) |-> (cnt_mcast == $past(cnt_mcast)));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 14,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              ring_base_load,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              mem_en,
  output logic              mem_we,
  output logic [3:0]        mem_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              st_ri,
  output logic              st_nis,
  output logic              st_ru,
  output logic              st_ais,
  output logic [CNT_W-1:0]  cnt_bytes,
  output logic [CNT_W-1:0]  cnt_frames,
  output logic [CNT_W-1:0]  cnt_bcast,
  output logic [CNT_W-1:0]  cnt_mcast
);
  localparam int FETCH_WORDS = 3;
  localparam int FETCH_LAST  = FETCH_WORDS + 1;

  rxw_state_e        state;
  logic [2:0]        fcnt;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] buf_q;
  logic              own_q;
  logic              wrap_q;
  logic [LEN_W-1:0]  idx;
  logic [LEN_W-1:0]  len_q;
  logic [31:0]       acc;
  logic [31:0]       acc_n;
  logic [3:0]        lane_be;
  logic [LEN_W:0]    wb_len;
  logic              beat;
  logic              short_f;
  logic              store_ok;
  logic              is_bcast;
  logic              is_mcast;

  assign s_ready  = (state == ST_DATA) || (state == ST_SKIP);
  assign beat     = s_valid && s_ready;
  assign wb_len   = {1'b0, len_q} + (LEN_W+1)'(CRC_BYTES);
  assign short_f  = len_q < LEN_W'(MIN_FRAME);
  assign store_ok = (state == ST_FIN) && !short_f && own_q;

  always_comb begin
    acc_n = acc;
    acc_n[8*idx[1:0] +: 8] = s_data;
    case (idx[1:0])
      2'd0:    lane_be = 4'b0001;
      2'd1:    lane_be = 4'b0011;
      2'd2:    lane_be = 4'b0111;
      default: lane_be = 4'b1111;
    endcase
  end

  rxw_classify #(.LEN_W(LEN_W)) u_class (
    .clk      (clk),
    .rst      (rst),
    .clr      (state == ST_IDLE),
    .beat     (beat && (state == ST_DATA)),
    .idx      (idx),
    .data     (s_data),
    .is_bcast (is_bcast),
    .is_mcast (is_mcast)
  );

  rxw_stats #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_stats (
    .clk        (clk),
    .rst        (rst),
    .upd        (store_ok),
    .add_bytes  (wb_len),
    .bcast      (is_bcast),
    .mcast      (is_mcast),
    .cnt_bytes  (cnt_bytes),
    .cnt_frames (cnt_frames),
    .cnt_bcast  (cnt_bcast),
    .cnt_mcast  (cnt_mcast)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      fcnt      <= '0;
      ptr_q     <= '0;
      buf_q     <= '0;
      own_q     <= 1'b0;
      wrap_q    <= 1'b0;
      idx       <= '0;
      len_q     <= '0;
      acc       <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_be    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      st_ri     <= 1'b0;
      st_nis    <= 1'b0;
      st_ru     <= 1'b0;
      st_ais    <= 1'b0;
    end else begin
      mem_en <= 1'b0;
      mem_we <= 1'b0;
      st_ri  <= 1'b0;
      st_nis <= 1'b0;
      st_ru  <= 1'b0;
      st_ais <= 1'b0;
      if (ring_base_load) ptr_q <= ring_base;
      case (state)
        ST_IDLE: begin
          if (s_valid) begin
            fcnt  <= '0;
            state <= rx_en ? ST_FETCH : ST_SKIP;
          end
        end
        ST_FETCH: begin
          fcnt <= fcnt + 1'b1;
          if (fcnt < 3'(FETCH_WORDS)) begin
            mem_en   <= 1'b1;
            mem_addr <= ptr_q + (ADDR_W'(fcnt) << 2);
          end
          if (fcnt == 3'd2) own_q  <= mem_rdata[OWN_BIT];
          if (fcnt == 3'd3) wrap_q <= mem_rdata[WRAP_BIT];
          if (fcnt == 3'(FETCH_LAST)) begin
            buf_q <= mem_rdata[ADDR_W-1:0];
            idx   <= '0;
            acc   <= '0;
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (beat) begin
            acc <= acc_n;
            idx <= idx + 1'b1;
            if (own_q && (idx[1:0] == 2'd3 || s_last)) begin
              mem_en    <= 1'b1;
              mem_we    <= 1'b1;
              mem_be    <= lane_be;
              mem_addr  <= buf_q + ADDR_W'({idx[LEN_W-1:2], 2'b00});
              mem_wdata <= acc_n;
            end
            if (s_last) begin
              len_q <= idx + 1'b1;
              state <= ST_FIN;
            end
          end
        end
        ST_SKIP: begin
          if (beat && s_last) state <= ST_IDLE;
        end
        ST_FIN: begin
          state <= ST_IDLE;
          if (short_f) begin
            st_ri  <= 1'b1;
            st_nis <= 1'b1;
          end else if (!own_q) begin
            st_ru  <= 1'b1;
            st_ais <= 1'b1;
          end else begin
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_be    <= 4'hF;
            mem_addr  <= ptr_q;
            mem_wdata <= (32'(wb_len) << 16) | WB_FLAGS;
            ptr_q     <= wrap_q ? ring_base : ptr_q + ADDR_W'(DESC_BYTES);
            st_ri     <= 1'b1;
            st_nis    <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  ru_pair_chk: assert property (@(posedge clk) disable iff (rst)
    st_ru |-> (st_ais && !st_ri && !st_nis));

  // R9
  ri_pair_chk: assert property (@(posedge clk) disable iff (rst)
    st_ri |-> (st_nis && !st_ais));

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((ptr_q != $past(ptr_q)) && !$past(ring_base_load)) |->
      ((ptr_q == $past(ptr_q) + ADDR_W'(DESC_BYTES)) || (ptr_q == $past(ring_base))));

  // R10
  no_read_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |-> !s_ready);
endmodule

// File: tb/sim_rx_ring_writer.sv
module sim_rx_ring_writer;
  localparam int CLK_NS = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 64;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] BUFS = 32'h400;
  localparam int NDESC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0;
  logic [ADDR_W-1:0] ring_base = BASE;
  logic ring_base_load = 1'b0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic s_last = 1'b0;
  logic s_ready;
  logic mem_en, mem_we;
  logic [3:0] mem_be;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic st_ri, st_nis, st_ru, st_ais;
  logic [CNT_W-1:0] cnt_bytes, cnt_frames, cnt_bcast, cnt_mcast;

  always #(CLK_NS/2) clk = ~clk;

  rx_ring_writer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .rx_en(rx_en), .ring_base(ring_base),
    .ring_base_load(ring_base_load), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .s_ready(s_ready), .mem_en(mem_en), .mem_we(mem_we),
    .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .st_ri(st_ri), .st_nis(st_nis), .st_ru(st_ru),
    .st_ais(st_ais), .cnt_bytes(cnt_bytes), .cnt_frames(cnt_frames),
    .cnt_bcast(cnt_bcast), .cnt_mcast(cnt_mcast)
  );

  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
      end
    end
  end

  int n_ri, n_nis, n_ru, n_ais, n_wr;
  always @(posedge clk) begin
    if (st_ri)  n_ri++;
    if (st_nis) n_nis++;
    if (st_ru)  n_ru++;
    if (st_ais) n_ais++;
    if (mem_en && mem_we) n_wr++;
  end

  int total = 0;
  int bad = 0;
  int exp_k = 0;
  longint e_bytes = 0, e_frames = 0, e_bcast = 0, e_mcast = 0;
  logic [7:0] fb [0:63];

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_counters(input string tag);
    chk(cnt_bytes  == e_bytes,  {tag, " cnt_bytes"},  cnt_bytes,  e_bytes);
    chk(cnt_frames == e_frames, {tag, " cnt_frames"}, cnt_frames, e_frames);
    chk(cnt_bcast  == e_bcast,  {tag, " cnt_bcast"},  cnt_bcast,  e_bcast);
    chk(cnt_mcast  == e_mcast,  {tag, " cnt_mcast"},  cnt_mcast,  e_mcast);
  endtask

  function automatic int dw(input int k, input int w);
    return int'((BASE + 32'(32*k)) >> 2) + w;
  endfunction

  function automatic int bw(input int k, input int i);
    return int'((BUFS + 32'(128*k)) >> 2) + i/4;
  endfunction

  // kind 0 unicast, 1 broadcast, 2 multicast, 3 near-broadcast multicast
  task automatic build(input int len, input int kind, input int seed);
    for (int i = 0; i < 64; i++) fb[i] = 8'((seed + i) * 7 + 3);
    case (kind)
      0: fb[0] = 8'h02;
      1: for (int i = 0; i < 6; i++) fb[i] = 8'hFF;
      2: fb[0] = 8'h01;
      default: begin
        for (int i = 0; i < 5; i++) fb[i] = 8'hFF;
        fb[5] = 8'hFE;
      end
    endcase
    if (len < 0) fb[0] = 8'h00;
  endtask

  task automatic send(input int len, input int exp_wait, input string tag);
    int waits;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = fb[i];
      s_last  = (i == len - 1);
      waits = 0;
      do begin
        @(posedge clk);
        waits++;
      end while (!s_ready);
      if (i == 0) chk(waits == exp_wait, {tag, " first-byte accept edge"}, waits, exp_wait);
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic run_frame(input int len, input int kind, input logic en, input logic own);
    int k;
    logic [31:0] w0;
    k = exp_k;
    build(len, kind, len);
    mem[dw(k, 0)] = own ? 32'h8000_0000 : 32'h0;
    mem[dw(k, 1)] = ((k == NDESC - 1) ? 32'h8000 : 32'h0) | 32'd64;
    mem[dw(k, 2)] = BUFS + 32'(128*k);
    for (int i = 0; i < 32; i++) mem[bw(k, 4*i)] = 32'hA5A5_A5A5;
    rx_en = en;
    n_ri = 0; n_nis = 0; n_ru = 0; n_ais = 0; n_wr = 0;
    send(len, en ? 7 : 2, en ? "R10" : "R2");
    repeat (3) @(posedge clk);
    @(negedge clk);
    w0 = mem[dw(k, 0)];
    if (!en) begin
      chk(n_wr == 0, "R2 memory writes", n_wr, 0);
      chk(n_ri + n_nis + n_ru + n_ais == 0, "R2 status pulses", n_ri + n_nis + n_ru + n_ais, 0);
      chk_counters("R2");
    end else if (len < 12) begin
      chk(n_ri == 1 && n_nis == 1, "R3 ri/nis pulses", n_ri + n_nis, 2);
      chk(n_ru == 0 && n_ais == 0, "R3 no ru/ais", n_ru + n_ais, 0);
      chk(w0 == (own ? 32'h8000_0000 : 32'h0), "R3 descriptor untouched", w0, own ? 32'h8000_0000 : 0);
      chk_counters("R3");
    end else if (!own) begin
      chk(n_ru == 1 && n_ais == 1, "R4 ru/ais pulses", n_ru + n_ais, 2);
      chk(n_ri == 0 && n_nis == 0, "R4 no ri/nis", n_ri + n_nis, 0);
      chk(n_wr == 0, "R4 memory writes", n_wr, 0);
      chk_counters("R4");
    end else begin
      chk(n_ri == 1 && n_nis == 1 && n_ru == 0 && n_ais == 0, "R9 ri/nis pulses",
          n_ri * 8 + n_nis * 4 + n_ru * 2 + n_ais, 12);
      chk(w0 == ((32'(len + 4) << 16) | 32'h300), "R6 R7 write-back word at expected slot",
          w0, (32'(len + 4) << 16) | 32'h300);
      for (int i = 0; i < ((len + 3) / 4) * 4; i++) begin
        logic [7:0] got, want;
        got  = mem[bw(k, i)][8*(i%4) +: 8];
        want = (i < len) ? fb[i] : 8'hA5;
        chk(got == want, "R5 buffer byte", got, want);
      end
      chk(mem[bw(k, 4*((len + 3) / 4))] == 32'hA5A5_A5A5, "R5 word past frame",
          mem[bw(k, 4*((len + 3) / 4))], 32'hA5A5_A5A5);
      e_bytes  += len + 4;
      e_frames += 1;
      if (kind == 1) e_bcast += 1;
      if (kind == 2 || kind == 3) e_mcast += 1;
      chk_counters("R8");
      exp_k = (k == NDESC - 1) ? 0 : k + 1;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(s_ready == 1'b0, "R1 s_ready", s_ready, 0);
    chk(mem_en == 1'b0, "R1 mem_en", mem_en, 0);
    chk({st_ri, st_nis, st_ru, st_ais} == 4'b0, "R1 pulses", {st_ri, st_nis, st_ru, st_ais}, 0);
    chk_counters("R1");
    ring_base_load = 1'b1;
    @(negedge clk);
    ring_base_load = 1'b0;

    // R5 R6 R8 R9: length sweep through the ring, wrapping on the flag (R7)
    for (int len = 12; len <= 60; len++) run_frame(len, len % 4, 1'b1, 1'b1);
    // R2 disabled frames leave everything, including the pointer
    run_frame(20, 1, 1'b0, 1'b1);
    run_frame(3, 0, 1'b0, 1'b1);
    // R3 short frames, owned and unowned
    for (int len = 1; len < 12; len++) run_frame(len, 0, 1'b1, len % 2 == 1);
    // R4 unowned descriptor
    run_frame(12, 2, 1'b1, 1'b0);
    run_frame(40, 1, 1'b1, 1'b0);
    // stored frame after drops still uses the same slot (R7)
    run_frame(25, 3, 1'b1, 1'b1);
    // R7 explicit base reload restarts at slot 0
    @(negedge clk);
    ring_base_load = 1'b1;
    @(negedge clk);
    ring_base_load = 1'b0;
    exp_k = 0;
    run_frame(33, 1, 1'b1, 1'b1);
    run_frame(14, 2, 1'b1, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule